// File: doc/BRIEF.md
# Floating-Point Coprocessor Issue Scoreboard

This block sits in front of a floating-point coprocessor. The coprocessor has three shared resources: a multiply-accumulate unit, a divide/square-root unit and a three-stage load/store path. Each cycle the block looks at one candidate operation: its class, two source register numbers and one destination register number. It then decides whether that operation may issue. It remembers how long each unit stays occupied, how the load/store stages are reserved over the next few cycles, and, for every destination register, how many cycles remain until its result is ready. Producers that feed an arithmetic consumer get a one-cycle forwarding shortcut.

The candidate is offered with `op_valid`. The block answers with `op_ready`, which depends only on the candidate's fields, `core_stall` and internal state. It never depends on `op_valid`. An operation issues in a cycle where both are high. The upstream side holds the same candidate until it is accepted. A held candidate is re-evaluated every cycle, and no state changes unless an issue takes place. When a candidate is refused, `stall_why` gives the reason. Only the first reason in a fixed priority order is reported.

Top module: `fp_issue_sb`

## Requirements
- R1: An operation issues in a cycle where `op_valid` and `op_ready` are both high. `stall_why` is 0 whenever `op_valid` is low or `op_ready` is high, and it is nonzero when a valid op is refused. The class codes on `op_class` are: 0 simple arithmetic (add, compare, convert, move), 1 multiply or multiply-accumulate, 2 single divide/sqrt, 3 double divide/sqrt, 4 single load or core-to-coprocessor move, 5 double load, 6 single store, 7 double store, 8 flag transfer. The codes 9 to 15 use no resource and write no register.
- R2: While `core_stall` is high, `op_ready` is low, and a valid op reports code 1.
- R3: The multiply-accumulate unit is held for 1 cycle by class 0, for 2 cycles by class 1 and for the issue cycle only by class 3. A class needing it while it is held reports code 3.
- R4: The divide unit is held for 14 cycles by class 2 and for 28 cycles by class 3. A class needing it while it is held reports code 4.
- R5: Class 8 cannot issue while either the multiply-accumulate unit or the divide unit is held, and it reports code 2.
- R6: Load/store stages are numbered 1 to 3. Classes 4 and 6 take stage 1 in the issue cycle and stage 2 in the next cycle. Classes 5 and 7 take all three stages in the issue cycle, stages 2 and 3 in the next cycle and stage 3 in the one after. A conflict with an earlier reservation reports code 5. As a result, a single load followed by a double load stalls 1 cycle, and two double loads in a row stall 2 cycles.
- R7: A producer issued in cycle t makes its destination readable in cycle t+L. L is 5 for class 0, 6 for class 1, 18 for class 2, 32 for class 3, 4 for class 4 and 5 for class 5. An earlier read of that register reports code 6. Classes 0 to 3 read both sources. Classes 6 and 7 read source A only.
- R8: When the consumer is class 0, 1, 2 or 3, the register is readable one cycle earlier, in cycle t+L-1. Stores get no such reduction.
- R9: A producer whose destination still has at least L cycles to go from an earlier producer is refused with code 7.
- R10: Reset frees all units, all load/store reservations and all register countdowns.
- R11: When several reasons apply, the lowest code is reported, in the order 1, 2, 3, 4, 5, 6, 7.
- R12: When a producer issues to a register whose countdown is still running, the new latency replaces the old countdown in that same cycle. The old countdown does not decrement that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_stall | input | 1 | Core held in its first execute stage |
| op_valid | input | 1 | Candidate operation present |
| op_ready | output | 1 | Candidate may issue this cycle |
| op_class | input | 4 | Operation class code (R1) |
| op_src_a | input | REG_W | First source register |
| op_src_b | input | REG_W | Second source register |
| op_dst | input | REG_W | Destination register |
| stall_why | output | 3 | Refusal reason code, 0 when none |

## Verification
Two functions can act on the same register in the same cycle: the ageing of a destination's countdown and a fresh issue that reloads that countdown. The bench provokes this by issuing a multiply to a register a few cycles after an add to it. It then issues a store reading that register, and the store must wait out the full new latency. If the two events merged wrongly, the register would become readable early. The load/store reservation shift and a new reservation can also coincide. Back-to-back single and double loads exercise this, and the stall counts must be exactly one and two cycles. Constrained random traffic over four registers, with a bench model of every rule, keeps provoking both collisions.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam int LS_STAGES = 3;
  localparam int LS_DEPTH  = 3;
  localparam int LAT_W     = 6;
  localparam int DIV_W     = 5;
  localparam int MAC_W     = 2;

  localparam int LAT_ARITH = 5;
  localparam int LAT_MUL   = 6;
  localparam int LAT_DIVS  = 18;
  localparam int LAT_DIVD  = 32;
  localparam int LAT_LDS   = 4;
  localparam int LAT_LDD   = 5;

  localparam int MUL_OCC   = 2;
  localparam int DIVS_OCC  = 14;
  localparam int DIVD_OCC  = 28;

  typedef enum logic [3:0] {
    OPC_ARITH = 4'd0,
    OPC_MUL   = 4'd1,
    OPC_DIVS  = 4'd2,
    OPC_DIVD  = 4'd3,
    OPC_LDS   = 4'd4,
    OPC_LDD   = 4'd5,
    OPC_STS   = 4'd6,
    OPC_STD   = 4'd7,
    OPC_FLAG  = 4'd8
  } opc_e;

  typedef enum logic [2:0] {
    WHY_NONE   = 3'd0,
    WHY_CORE   = 3'd1,
    WHY_SERIAL = 3'd2,
    WHY_MAC    = 3'd3,
    WHY_DIV    = 3'd4,
    WHY_LS     = 3'd5,
    WHY_RAW    = 3'd6,
    WHY_WAW    = 3'd7
  } why_e;

  typedef logic [LS_STAGES-1:0] ls_mask_t;

  typedef struct packed {
    logic [MAC_W-1:0]          mac_cyc;
    logic [DIV_W-1:0]          div_cyc;
    logic [LAT_W-1:0]          lat;
    logic                      wr;
    logic                      fwd;
    logic                      rd_a;
    logic                      rd_b;
    logic                      arith;
    logic                      serial;
    ls_mask_t [LS_DEPTH-1:0]   ls_need;
  } op_attr_t;

  function automatic op_attr_t decode_op(input logic [3:0] c);
    op_attr_t a;
    a = '0;
    case (c)
      OPC_ARITH: begin
        a.mac_cyc = MAC_W'(1);
        a.lat = LAT_W'(LAT_ARITH);
        a.wr = 1'b1; a.fwd = 1'b1;
        a.rd_a = 1'b1; a.rd_b = 1'b1; a.arith = 1'b1;
      end
      OPC_MUL: begin
        a.mac_cyc = MAC_W'(MUL_OCC);
        a.lat = LAT_W'(LAT_MUL);
        a.wr = 1'b1; a.fwd = 1'b1;
        a.rd_a = 1'b1; a.rd_b = 1'b1; a.arith = 1'b1;
      end
      OPC_DIVS: begin
        a.div_cyc = DIV_W'(DIVS_OCC);
        a.lat = LAT_W'(LAT_DIVS);
        a.wr = 1'b1; a.fwd = 1'b1;
        a.rd_a = 1'b1; a.rd_b = 1'b1; a.arith = 1'b1;
      end
      OPC_DIVD: begin
        a.mac_cyc = MAC_W'(1);
        a.div_cyc = DIV_W'(DIVD_OCC);
        a.lat = LAT_W'(LAT_DIVD);
        a.wr = 1'b1; a.fwd = 1'b1;
        a.rd_a = 1'b1; a.rd_b = 1'b1; a.arith = 1'b1;
      end
      OPC_LDS: begin
        a.lat = LAT_W'(LAT_LDS);
        a.wr = 1'b1; a.fwd = 1'b1;
        a.ls_need[0] = 3'b001;
        a.ls_need[1] = 3'b010;
      end
      OPC_LDD: begin
        a.lat = LAT_W'(LAT_LDD);
        a.wr = 1'b1; a.fwd = 1'b1;
        a.ls_need[0] = 3'b111;
        a.ls_need[1] = 3'b110;
        a.ls_need[2] = 3'b100;
      end
      OPC_STS: begin
        a.rd_a = 1'b1;
        a.ls_need[0] = 3'b001;
        a.ls_need[1] = 3'b010;
      end
      OPC_STD: begin
        a.rd_a = 1'b1;
        a.ls_need[0] = 3'b111;
        a.ls_need[1] = 3'b110;
        a.ls_need[2] = 3'b100;
      end
      OPC_FLAG: begin
        a.serial = 1'b1;
      end
      default: ;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/fsb_decode.sv
module fsb_decode
  import fsb_pkg::*;
(
  input  logic [3:0] op_class,
  output op_attr_t   attr
);
  always_comb attr = decode_op(op_class);
endmodule

// File: rtl/fsb_unit_track.sv
module fsb_unit_track #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] cycles,
  output logic         busy
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (take && (cycles != '0)) begin
      left_q <= cycles - W'(1);
    end else if (left_q != '0) begin
      left_q <= left_q - W'(1);
    end
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/fsb_ls_reserve.sv
module fsb_ls_reserve #(
  parameter int STAGES = 3,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [DEPTH-1:0][STAGES-1:0]  need,
  output logic                          conflict
);
  logic [DEPTH-1:0][STAGES-1:0] occ_q;
  logic [DEPTH-1:0]             clash;

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign clash[k] = |(occ_q[k] & need[k]);
    if (k < DEPTH - 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) occ_q[k] <= '0;
        else        occ_q[k] <= occ_q[k+1] | (take ? need[k+1] : '0);
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        occ_q[k] <= '0;
      end
    end
  end

  assign conflict = |clash;
endmodule

// File: rtl/fsb_reg_timer.sv
module fsb_reg_timer #(
  parameter int NREGS = 32,
  parameter int REG_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  input  logic [REG_W-1:0] dst,
  input  logic             rd_a,
  input  logic             rd_b,
  input  logic             arith_use,
  input  logic             wr_chk,
  input  logic [CNT_W-1:0] new_lat,
  input  logic             new_fwd,
  input  logic             wr_en,
  output logic             raw_hit,
  output logic             waw_hit
);
  logic [NREGS-1:0][CNT_W-1:0] cnt_q;
  logic [NREGS-1:0]            fwd_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic load;
    assign load = wr_en && (dst == REG_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        fwd_q[i] <= 1'b0;
      end else if (load) begin
        cnt_q[i] <= new_lat - CNT_W'(1);
        fwd_q[i] <= new_fwd;
      end else if (cnt_q[i] != '0) begin
        cnt_q[i] <= cnt_q[i] - CNT_W'(1);
      end
    end
  end

  logic [CNT_W-1:0] cnt_a, cnt_b, cnt_d;
  logic [CNT_W-1:0] lim_a, lim_b;

  always_comb begin
    cnt_a = cnt_q[src_a];
    cnt_b = cnt_q[src_b];
    cnt_d = cnt_q[dst];
    lim_a = (arith_use && fwd_q[src_a]) ? CNT_W'(1) : '0;
    lim_b = (arith_use && fwd_q[src_b]) ? CNT_W'(1) : '0;
    raw_hit = (rd_a && (cnt_a > lim_a)) || (rd_b && (cnt_b > lim_b));
    waw_hit = wr_chk && (cnt_d >= new_lat);
  end
endmodule

// File: rtl/fp_issue_sb.sv
module fp_issue_sb
  import fsb_pkg::*;
#(
  parameter int NUM_FREGS = 32,
  localparam int REG_W = $clog2(NUM_FREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_stall,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [3:0]       op_class,
  input  logic [REG_W-1:0] op_src_a,
  input  logic [REG_W-1:0] op_src_b,
  input  logic [REG_W-1:0] op_dst,
  output logic [2:0]       stall_why
);
  op_attr_t attr;
  logic     mac_busy, div_busy, ls_conflict, raw_hit, waw_hit;
  logic     fire;
  why_e     block;

  fsb_decode u_decode (
    .op_class (op_class),
    .attr     (attr)
  );

  fsb_unit_track #(.W(MAC_W)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (fire),
    .cycles (attr.mac_cyc),
    .busy   (mac_busy)
  );

  fsb_unit_track #(.W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (fire),
    .cycles (attr.div_cyc),
    .busy   (div_busy)
  );

  fsb_ls_reserve #(.STAGES(LS_STAGES), .DEPTH(LS_DEPTH)) u_ls (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (fire),
    .need     (attr.ls_need),
    .conflict (ls_conflict)
  );

  fsb_reg_timer #(.NREGS(NUM_FREGS), .REG_W(REG_W), .CNT_W(LAT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_a     (op_src_a),
    .src_b     (op_src_b),
    .dst       (op_dst),
    .rd_a      (attr.rd_a),
    .rd_b      (attr.rd_b),
    .arith_use (attr.arith),
    .wr_chk    (attr.wr),
    .new_lat   (attr.lat),
    .new_fwd   (attr.fwd),
    .wr_en     (fire && attr.wr),
    .raw_hit   (raw_hit),
    .waw_hit   (waw_hit)
  );

  always_comb begin
    if (core_stall)                                  block = WHY_CORE;
    else if (attr.serial && (mac_busy || div_busy))  block = WHY_SERIAL;
    else if ((attr.mac_cyc != '0) && mac_busy)       block = WHY_MAC;
    else if ((attr.div_cyc != '0) && div_busy)       block = WHY_DIV;
    else if (ls_conflict)                            block = WHY_LS;
    else if (raw_hit)                                block = WHY_RAW;
    else if (waw_hit)                                block = WHY_WAW;
    else                                             block = WHY_NONE;
  end

  assign op_ready  = (block == WHY_NONE);
  assign fire      = op_valid && op_ready;
  assign stall_why = op_valid ? 3'(block) : 3'(WHY_NONE);
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       core_stall,
  input logic       op_valid,
  input logic       op_ready,
  input logic [3:0] op_class,
  input logic [2:0] stall_why,
  input logic       mac_busy,
  input logic       div_busy
);
  logic fire;
  logic mac_class, div_class;
  assign fire      = rst_n && op_valid && op_ready;
  assign mac_class = (op_class == 4'd0) || (op_class == 4'd1) || (op_class == 4'd3);
  assign div_class = (op_class == 4'd2) || (op_class == 4'd3);

  a_r1_code_matches_ready: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_ready == (stall_why == 3'd0)));

  a_r1_idle_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (stall_why == 3'd0));

  a_r2_core_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (!op_ready && (!op_valid || stall_why == 3'd1)));

  a_r3_mul_holds_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire && op_class == 4'd1) && mac_class) |-> !op_ready);

  a_r4_div_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire && op_class == 4'd2) && div_class) |-> !op_ready);

  a_r5_flag_waits_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && op_class == 4'd8) |-> (!mac_busy && !div_busy));

  a_r6_double_pair_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire && op_class == 4'd5) && op_class == 4'd5) |-> !op_ready);

  a_r10_reset_frees_units: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!mac_busy && !div_busy));
endmodule

bind fp_issue_sb fsb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_stall (core_stall),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .op_class   (op_class),
  .stall_why  (stall_why),
  .mac_busy   (mac_busy),
  .div_busy   (div_busy)
);

// File: tb/fp_issue_sb_bench.sv
`timescale 1ns/1ps
module fp_issue_sb_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       core_stall = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_class = '0;
  logic [4:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
  logic [2:0] stall_why;

  always #2.5 clk = ~clk;

  fp_issue_sb u_fp_issue_sb (
    .clk(clk), .rst_n(rst_n), .core_stall(core_stall),
    .op_valid(op_valid), .op_ready(op_ready), .op_class(op_class),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
    .stall_why(stall_why)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int rc[32];
  bit rf[32];
  int macq, divq;
  bit [2:0] occ[3];
  int last_why;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Class attributes as listed in the requirements (R1, R3, R4, R6, R7).
  function automatic void attrs(input int c, output int mac, output int div, output int lat,
                                output bit wr, output bit ra, output bit rb, output bit ar,
                                output bit ser, output bit [2:0] n0, output bit [2:0] n1,
                                output bit [2:0] n2);
    mac = 0; div = 0; lat = 0; wr = 0; ra = 0; rb = 0; ar = 0; ser = 0;
    n0 = 0; n1 = 0; n2 = 0;
    case (c)
      0: begin mac = 1; lat = 5;  wr = 1; ra = 1; rb = 1; ar = 1; end
      1: begin mac = 2; lat = 6;  wr = 1; ra = 1; rb = 1; ar = 1; end
      2: begin div = 14; lat = 18; wr = 1; ra = 1; rb = 1; ar = 1; end
      3: begin mac = 1; div = 28; lat = 32; wr = 1; ra = 1; rb = 1; ar = 1; end
      4: begin lat = 4; wr = 1; n0 = 3'b001; n1 = 3'b010; end
      5: begin lat = 5; wr = 1; n0 = 3'b111; n1 = 3'b110; n2 = 3'b100; end
      6: begin ra = 1; n0 = 3'b001; n1 = 3'b010; end
      7: begin ra = 1; n0 = 3'b111; n1 = 3'b110; n2 = 3'b100; end
      8: ser = 1;
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    case (w)
      1: return "R2";
      2: return "R5";
      3: return "R3";
      4: return "R4";
      5: return "R6";
      6: return "R7";
      7: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 32; i++) begin rc[i] = 0; rf[i] = 0; end
    macq = 0; divq = 0;
    for (int k = 0; k < 3; k++) occ[k] = 0;
  endtask

  task automatic step(input bit v, input int c, input int a, input int b, input int d,
                      input bit st, output bit got);
    int mac, div, lat, ew;
    bit wr, ra, rb, ar, ser, er, fire;
    bit [2:0] n0, n1, n2;
    @(negedge clk);
    op_valid = v; op_class = 4'(c); op_src_a = 5'(a); op_src_b = 5'(b);
    op_dst = 5'(d); core_stall = st;
    #1;
    attrs(c, mac, div, lat, wr, ra, rb, ar, ser, n0, n1, n2);
    if (st) ew = 1;
    else if (ser && (macq > 0 || divq > 0)) ew = 2;
    else if (mac > 0 && macq > 0) ew = 3;
    else if (div > 0 && divq > 0) ew = 4;
    else if (((occ[0] & n0) | (occ[1] & n1) | (occ[2] & n2)) != 0) ew = 5;
    else if ((ra && rc[a] > ((ar && rf[a]) ? 1 : 0)) ||
             (rb && rc[b] > ((ar && rf[b]) ? 1 : 0))) ew = 6;
    else if (wr && rc[d] >= lat) ew = 7;
    else ew = 0;
    er = (ew == 0);
    got = op_ready;
    last_why = int'(stall_why);
    chk(op_ready == er, tag_of(ew), int'(op_ready), int'(er));
    chk(int'(stall_why) == (v ? ew : 0), v ? tag_of(ew) : "R1", int'(stall_why), v ? ew : 0);
    fire = v && er;
    for (int i = 0; i < 32; i++) begin
      if (fire && wr && d == i) begin rc[i] = lat - 1; rf[i] = 1; end
      else if (rc[i] > 0) rc[i]--;
    end
    if (fire && mac > 0) macq = mac - 1; else if (macq > 0) macq--;
    if (fire && div > 0) divq = div - 1; else if (divq > 0) divq--;
    occ[0] = occ[1] | (fire ? n1 : 3'b0);
    occ[1] = occ[2] | (fire ? n2 : 3'b0);
    occ[2] = 0;
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, g);
  endtask

  task automatic wait_issue(input int c, input int a, input int b, input int d, output int stalls);
    bit g;
    stalls = 0;
    for (int i = 0; i < 100; i++) begin
      step(1, c, a, b, d, 0, g);
      if (g) break;
      stalls++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; op_valid = 0; core_stall = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit g;
    int s;
    void'($urandom(32'd20240611));
    do_reset();

    // R10: after reset every unit and register is free
    step(1, 8, 0, 0, 0, 0, g);
    chk(g == 1, "R10 flag ready after reset", g, 1);
    step(1, 0, 3, 4, 5, 0, g);
    chk(g == 1, "R10 arith ready after reset", g, 1);
    idle(40);

    // R6: single then double load, then double pairs
    step(1, 4, 0, 0, 1, 0, g); chk(g == 1, "R6 single load issues", g, 1);
    wait_issue(5, 0, 0, 2, s); chk(s == 1, "R6 single->double stall", s, 1);
    wait_issue(5, 0, 0, 3, s); chk(s == 2, "R6 double->double stall", s, 2);
    idle(40);

    // R7/R8: arith forwarding vs store without forwarding
    step(1, 0, 0, 0, 5, 0, g);
    wait_issue(0, 5, 0, 7, s); chk(s == 3, "R8 arith consumer forwarded", s, 3);
    idle(40);
    step(1, 0, 0, 0, 6, 0, g);
    wait_issue(6, 6, 0, 0, s); chk(s == 4, "R8 store gets no forwarding", s, 4);
    idle(40);
    step(1, 4, 0, 0, 12, 0, g);
    wait_issue(7, 12, 0, 0, s); chk(s == 3, "R7 load latency to store", s, 3);
    idle(40);

    // R3/R4/R5: unit occupancy and serialisation
    step(1, 1, 0, 0, 13, 0, g);
    wait_issue(1, 0, 0, 14, s); chk(s == 1, "R3 multiply holds two cycles", s, 1);
    idle(40);
    step(1, 2, 0, 0, 8, 0, g);
    wait_issue(8, 0, 0, 0, s); chk(s == 13, "R5 flag waits for divide", s, 13);
    idle(40);
    step(1, 3, 0, 0, 15, 0, g);
    step(1, 0, 0, 0, 16, 0, g); chk(g == 1, "R3 double divide frees mac", g, 1);
    wait_issue(2, 0, 0, 17, s); chk(s == 26, "R4 divide held 28 cycles", s, 26);
    idle(40);

    // R9 and R11
    step(1, 2, 0, 0, 9, 0, g);
    step(1, 0, 0, 0, 9, 0, g); chk(last_why == 7, "R9 write-after-write", last_why, 7);
    step(1, 8, 0, 0, 0, 1, g); chk(last_why == 1, "R11 core stall first", last_why, 1);
    step(1, 8, 0, 0, 0, 0, g); chk(last_why == 2, "R11 serial before units", last_why, 2);
    idle(40);
    step(1, 1, 0, 0, 20, 0, g);
    step(1, 8, 0, 0, 0, 0, g); chk(last_why == 2, "R11 serial before mac", last_why, 2);
    idle(40);

    // R12: reload of a running countdown wins over ageing
    step(1, 0, 0, 0, 10, 0, g);
    step(1, 1, 0, 0, 10, 0, g); chk(g == 1, "R12 reload issues", g, 1);
    wait_issue(6, 10, 0, 0, s); chk(s == 5, "R12 new latency replaces old", s, 5);
    idle(40);

    // Random traffic over four registers
    for (int i = 0; i < 4000; i++)
      step(($urandom % 8) != 0, $urandom % 9, $urandom % 4, $urandom % 4,
           $urandom % 4, ($urandom % 8) == 0, g);

    // R10: reset in the middle of a busy divide
    step(1, 3, 0, 0, 1, 0, g);
    do_reset();
    step(1, 8, 0, 0, 0, 0, g); chk(g == 1, "R10 reset clears divide", g, 1);
    step(1, 6, 1, 0, 0, 0, g); chk(g == 1, "R10 reset clears countdown", g, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule